// File: doc/BRIEF.md
# Mode-Switching Indirect Jump Sequencer

This block is a reduced instruction-fetch sequencer for a processor that addresses a 24-bit space and also runs in a 16-bit compatibility mode. It carries out one instruction only: the jump whose target comes from a register. It reads opcode bytes through a plain asynchronous memory read port and takes the target from a 24-bit pointer input. It then loads the program counter and sets the wide-mode bit.

In compatibility mode (mode bit 0), the sequencer forms every fetch address by joining an 8-bit page-base register above the low 16 bits of the counter. In wide mode (mode bit 1), the full 24-bit counter is the address. A size prefix before the jump opcode can force a 24-bit or a 16-bit load, and that load also switches the mode. A done pulse marks a completed jump. An illegal pulse marks a byte sequence the sequencer refuses. After either pulse, fetching starts again at once.

Top module: `ijump_seq`

## Requirements
- R1: A synchronous active-high reset clears the counter, the page base, the mode bit, the fetch address, done and illegal.
- R2: While the mode bit is 0, `fetch_addr` equals {page base, pc[15:0]}. While it is 1, `fetch_addr` equals pc[23:0].
- R3: Every fetched opcode byte advances the counter by one. In mode 0 the increment wraps inside pc[15:0] and leaves pc[23:16] alone. In mode 1 it wraps across all 24 bits.
- R4: In mode 0, a lone 0xE9 byte loads pc[15:0] from the pointer's low 16 bits, keeps pc[23:16], and leaves the mode at 0. Done rises on the third clock edge after fetch begins.
- R5: In mode 1, a lone 0xE9 byte loads all 24 counter bits from the pointer and leaves the mode at 1. Done rises on the third edge.
- R6: In mode 0, prefix 0x49 followed by 0xE9 loads all 24 bits from the pointer and sets the mode to 1. Done rises on the fourth edge.
- R7: In mode 1, prefix 0x52 followed by 0xE9 loads pc[15:0] from the pointer, keeps pc[23:16], and clears the mode to 0. The next fetch address becomes {page base, pointer[15:0]}. Done rises on the fourth edge.
- R8: Prefix 0x52 in mode 0, or prefix 0x49 in mode 1, raises illegal on the second edge. The counter keeps only its one fetch increment and the mode is unchanged.
- R9: A legal prefix followed by any byte other than 0xE9 raises illegal on the third edge. The counter keeps its two fetch increments and the mode is unchanged.
- R10: A first byte that is neither 0xE9 nor 0x49 nor 0x52 raises illegal on the second edge, with the counter advanced by one.
- R11: Done and illegal are each high for a single cycle, never at the same time. Fetching of the next byte starts on the following edge.
- R12: Asserting `base_we` loads `base_wdata` into the page base on that edge. Every fetch address formed in mode 0 from then on uses the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | 8 | Opcode byte read at `fetch_addr` in the same cycle |
| jump_src | input | 24 | Pointer register holding the jump target |
| base_we | input | 1 | Page-base write enable |
| base_wdata | input | 8 | New page-base value |
| fetch_addr | output | 24 | Registered effective fetch address |
| pc | output | 24 | Program counter |
| mode | output | 1 | Wide-mode bit (1 = 24-bit, 0 = compatibility) |
| done | output | 1 | One-cycle pulse when a jump completes |
| illegal | output | 1 | One-cycle pulse when a byte sequence is refused |

## Verification
The load checks compare the counter against the pointer value from the cycle before done. They therefore take for granted that `jump_src` holds steady through the execute cycle. The stimulus sets the pointer at the start of each instruction and changes it only after the pulse. The memory model returns the expected byte only at the addresses the requirements predict, and 0xFF anywhere else. A wrong fetch address therefore shows up as an illegal pulse rather than as a silent pass. Page-base writes are issued only on the first fetch edge of an instruction, so the bench can predict which fetches see the old base and which see the new one.

// File: rtl/ijump_pkg.sv
package ijump_pkg;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_DECODE,
    ST_FETCH2,
    ST_EXEC
  } state_e;

  typedef enum logic [1:0] {
    KIND_JUMP,
    KIND_PREFIX,
    KIND_BAD
  } kind_e;

  typedef enum logic [1:0] {
    PC_HOLD,
    PC_INC,
    PC_LOAD
  } pcop_e;

endpackage

// File: rtl/ijump_decode.sv
// Classifies the first opcode byte against the current mode.
module ijump_decode #(
  parameter int              OP_W         = 8,
  parameter logic [OP_W-1:0] OP_JUMP      = 8'hE9,
  parameter logic [OP_W-1:0] OP_PFX_SHORT = 8'h52,
  parameter logic [OP_W-1:0] OP_PFX_LONG  = 8'h49
) (
  input  logic [OP_W-1:0]   op,
  input  logic              wide,
  output ijump_pkg::kind_e  kind,
  output logic              want_long
);

  always_comb begin
    kind      = ijump_pkg::KIND_BAD;
    want_long = wide;
    if (op == OP_JUMP) begin
      kind = ijump_pkg::KIND_JUMP;
    end else if (op == OP_PFX_LONG && !wide) begin
      kind      = ijump_pkg::KIND_PREFIX;
      want_long = 1'b1;
    end else if (op == OP_PFX_SHORT && wide) begin
      kind      = ijump_pkg::KIND_PREFIX;
      want_long = 1'b0;
    end
  end

endmodule

// File: rtl/ijump_pc_next.sv
// Next program counter: hold, mode-aware increment, or narrow/wide load.
module ijump_pc_next #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic              wide,
  input  logic [ADDR_W-1:0] src,
  input  ijump_pkg::pcop_e  op,
  input  logic              load_long,
  output logic [ADDR_W-1:0] pc_nxt
);

  localparam logic [ADDR_W-1:0] ONE_W = ADDR_W'(1);
  localparam logic [LOW_W-1:0]  ONE_L = LOW_W'(1);

  always_comb begin
    pc_nxt = pc_cur;
    case (op)
      ijump_pkg::PC_INC: begin
        if (wide) pc_nxt = pc_cur + ONE_W;
        else      pc_nxt = {pc_cur[ADDR_W-1:LOW_W], pc_cur[LOW_W-1:0] + ONE_L};
      end
      ijump_pkg::PC_LOAD: begin
        if (load_long) pc_nxt = src;
        else           pc_nxt = {pc_cur[ADDR_W-1:LOW_W], src[LOW_W-1:0]};
      end
      default: pc_nxt = pc_cur;
    endcase
  end

endmodule

// File: rtl/ijump_addr_form.sv
// Effective address: page base joined to the low counter in compatibility mode.
module ijump_addr_form #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16,
  localparam int BASE_W = ADDR_W - LOW_W
) (
  input  logic [ADDR_W-1:0] pc_in,
  input  logic              wide,
  input  logic [BASE_W-1:0] base,
  output logic [ADDR_W-1:0] addr
);

  always_comb begin
    if (wide) addr = pc_in;
    else      addr = {base, pc_in[LOW_W-1:0]};
  end

endmodule

// File: rtl/ijump_seq.sv
module ijump_seq #(
  parameter int                   ADDR_W       = 24,
  parameter int                   LOW_W        = 16,
  parameter int                   OP_W         = 8,
  parameter logic [OP_W-1:0]      OP_JUMP      = 8'hE9,
  parameter logic [OP_W-1:0]      OP_PFX_SHORT = 8'h52,
  parameter logic [OP_W-1:0]      OP_PFX_LONG  = 8'h49
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [OP_W-1:0]             mem_rdata,
  input  logic [ADDR_W-1:0]           jump_src,
  input  logic                        base_we,
  input  logic [ADDR_W-LOW_W-1:0]     base_wdata,
  output logic [ADDR_W-1:0]           fetch_addr,
  output logic [ADDR_W-1:0]           pc,
  output logic                        mode,
  output logic                        done,
  output logic                        illegal
);

  import ijump_pkg::*;

  localparam int BASE_W = ADDR_W - LOW_W;

  state_e              state_q, state_n;
  logic [OP_W-1:0]     op_q, op_n;
  logic                long_q, long_n;
  logic [BASE_W-1:0]   base_q, base_n;
  logic                mode_n;
  logic                done_n, ill_n;
  pcop_e               pc_op;
  logic [ADDR_W-1:0]   pc_n;
  logic [ADDR_W-1:0]   fa_n;
  kind_e               kind;
  logic                want_long;

  ijump_decode #(
    .OP_W(OP_W), .OP_JUMP(OP_JUMP),
    .OP_PFX_SHORT(OP_PFX_SHORT), .OP_PFX_LONG(OP_PFX_LONG)
  ) u_dec (
    .op(op_q), .wide(mode), .kind(kind), .want_long(want_long)
  );

  ijump_pc_next #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_pcn (
    .pc_cur(pc), .wide(mode), .src(jump_src), .op(pc_op),
    .load_long(long_q), .pc_nxt(pc_n)
  );

  ijump_addr_form #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_addr (
    .pc_in(pc_n), .wide(mode_n), .base(base_n), .addr(fa_n)
  );

  always_comb begin
    state_n = state_q;
    op_n    = op_q;
    long_n  = long_q;
    mode_n  = mode;
    done_n  = 1'b0;
    ill_n   = 1'b0;
    pc_op   = PC_HOLD;
    base_n  = base_we ? base_wdata : base_q;
    case (state_q)
      ST_FETCH: begin
        op_n    = mem_rdata;
        pc_op   = PC_INC;
        state_n = ST_DECODE;
      end
      ST_DECODE: begin
        case (kind)
          KIND_JUMP: begin
            long_n  = want_long;
            state_n = ST_EXEC;
          end
          KIND_PREFIX: begin
            long_n  = want_long;
            state_n = ST_FETCH2;
          end
          default: begin
            ill_n   = 1'b1;
            state_n = ST_FETCH;
          end
        endcase
      end
      ST_FETCH2: begin
        pc_op = PC_INC;
        if (mem_rdata == OP_JUMP) begin
          state_n = ST_EXEC;
        end else begin
          ill_n   = 1'b1;
          state_n = ST_FETCH;
        end
      end
      ST_EXEC: begin
        pc_op   = PC_LOAD;
        mode_n  = long_q;
        done_n  = 1'b1;
        state_n = ST_FETCH;
      end
      default: state_n = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_FETCH;
      op_q       <= '0;
      long_q     <= 1'b0;
      base_q     <= '0;
      pc         <= '0;
      mode       <= 1'b0;
      fetch_addr <= '0;
      done       <= 1'b0;
      illegal    <= 1'b0;
    end else begin
      state_q    <= state_n;
      op_q       <= op_n;
      long_q     <= long_n;
      base_q     <= base_n;
      pc         <= pc_n;
      mode       <= mode_n;
      fetch_addr <= fa_n;
      done       <= done_n;
      illegal    <= ill_n;
    end
  end

endmodule

// File: rtl/ijump_chk.sv
module ijump_chk #(
  parameter int ADDR_W = 24,
  parameter int LOW_W  = 16
) (
  input logic                    clk,
  input logic                    rst,
  input logic [ADDR_W-1:0]       src,
  input logic [ADDR_W-1:0]       pc,
  input logic                    mode,
  input logic [ADDR_W-1:0]       fetch_addr,
  input logic [ADDR_W-LOW_W-1:0] base,
  input logic                    done,
  input logic                    illegal
);

  // R2
  narrow_addr_chk: assert property (@(posedge clk) disable iff (rst)
    !mode |-> fetch_addr == {base, pc[LOW_W-1:0]});

  // R2
  wide_addr_chk: assert property (@(posedge clk) disable iff (rst)
    mode |-> fetch_addr == pc);

  // R11
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && illegal));

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  illegal_single_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |=> !illegal);

  // R6
  mode_switch_chk: assert property (@(posedge clk) disable iff (rst)
    (mode != $past(mode)) |-> done);

  // R5
  wide_load_chk: assert property (@(posedge clk) disable iff (rst)
    (done && mode) |-> pc == $past(src));

  // R4
  narrow_load_chk: assert property (@(posedge clk) disable iff (rst)
    (done && !mode) |-> pc[LOW_W-1:0] == $past(src[LOW_W-1:0]));

  // R8
  illegal_mode_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> mode == $past(mode));

endmodule

bind ijump_seq ijump_chk #(.ADDR_W(ADDR_W), .LOW_W(LOW_W)) u_chk (
  .clk(clk), .rst(rst), .src(jump_src), .pc(pc), .mode(mode),
  .fetch_addr(fetch_addr), .base(base_q), .done(done), .illegal(illegal)
);

// File: tb/ijump_seq_test.sv
module ijump_seq_test;

  typedef struct packed {
    logic [3:0]  req;
    logic        we;
    logic [7:0]  wb;
    logic [7:0]  b0;
    logic [7:0]  b1;
    logic [23:0] src;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [0:NV-1] = '{
    '{4'd4,  1'b1, 8'h12, 8'hE9, 8'h00, 24'hAB3456}, // R4 + R12 base write
    '{4'd6,  1'b0, 8'h00, 8'h49, 8'hE9, 24'h7F0010}, // R6
    '{4'd5,  1'b0, 8'h00, 8'hE9, 8'h00, 24'hFFFFFF}, // R5
    '{4'd3,  1'b0, 8'h00, 8'hE9, 8'h00, 24'h010203}, // R3 24-bit wrap
    '{4'd9,  1'b0, 8'h00, 8'h52, 8'h00, 24'h000000}, // R9
    '{4'd8,  1'b0, 8'h00, 8'h49, 8'h00, 24'h000000}, // R8
    '{4'd10, 1'b0, 8'h00, 8'h00, 8'h00, 24'h000000}, // R10
    '{4'd7,  1'b0, 8'h00, 8'h52, 8'hE9, 24'hCCFFFF}, // R7
    '{4'd3,  1'b0, 8'h00, 8'hE9, 8'h00, 24'h550042}, // R3 16-bit wrap
    '{4'd8,  1'b0, 8'h00, 8'h52, 8'h00, 24'h000000}, // R8
    '{4'd9,  1'b0, 8'h00, 8'h49, 8'h37, 24'h000000}, // R9
    '{4'd12, 1'b1, 8'h80, 8'h49, 8'hE9, 24'h001234}, // R12 + R6
    '{4'd7,  1'b0, 8'h00, 8'h52, 8'hE9, 24'hAABEEF}  // R7
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  mem_rdata;
  logic [23:0] jump_src = '0;
  logic        base_we = 1'b0;
  logic [7:0]  base_wdata = '0;
  logic [23:0] fetch_addr, pc;
  logic        mode, done, illegal;

  logic [23:0] a0 = 24'hFFFFFF, a1 = 24'hFFFFFF;
  logic [7:0]  b0 = 8'hFF, b1 = 8'hFF;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  assign mem_rdata = (fetch_addr == a0) ? b0 : ((fetch_addr == a1) ? b1 : 8'hFF);

  ijump_seq uut (
    .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .jump_src(jump_src),
    .base_we(base_we), .base_wdata(base_wdata), .fetch_addr(fetch_addr),
    .pc(pc), .mode(mode), .done(done), .illegal(illegal)
  );

  function automatic logic [23:0] f_addr(input logic [23:0] p, input logic m, input logic [7:0] b);
    return m ? p : {b, p[15:0]};
  endfunction

  function automatic logic [23:0] f_inc(input logic [23:0] p, input logic m);
    return m ? p + 24'd1 : {p[23:16], p[15:0] + 16'd1};
  endfunction

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not complete");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] m_pc, pc1, e_pc;
    logic        m_mode, e_mode, e_done;
    logic [7:0]  m_base;
    int          e_cyc, n;
    bit          got;

    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(1, "reset pc", pc, 0);
    check(1, "reset mode", mode, 0);
    check(1, "reset fetch_addr", fetch_addr, 0);
    check(1, "reset done", done, 0);
    check(1, "reset illegal", illegal, 0);
    m_pc = '0; m_mode = 1'b0; m_base = '0;

    for (int i = 0; i < NV; i++) begin
      a0 = f_addr(m_pc, m_mode, m_base);
      b0 = VEC[i].b0;
      b1 = VEC[i].b1;
      jump_src = VEC[i].src;
      base_we = VEC[i].we;
      base_wdata = VEC[i].wb;
      if (VEC[i].we) m_base = VEC[i].wb;
      pc1 = f_inc(m_pc, m_mode);
      a1 = f_addr(pc1, m_mode, m_base);

      e_mode = m_mode;
      if (VEC[i].b0 == 8'hE9) begin
        e_done = 1'b1; e_cyc = 3;
        e_pc = m_mode ? VEC[i].src : {pc1[23:16], VEC[i].src[15:0]};
      end else if ((VEC[i].b0 == 8'h49 && !m_mode) || (VEC[i].b0 == 8'h52 && m_mode)) begin
        if (VEC[i].b1 == 8'hE9) begin
          e_done = 1'b1; e_cyc = 4;
          e_mode = (VEC[i].b0 == 8'h49);
          e_pc = e_mode ? VEC[i].src : {pc1[23:16], VEC[i].src[15:0]};
        end else begin
          e_done = 1'b0; e_cyc = 3; e_pc = f_inc(pc1, m_mode);
        end
      end else begin
        e_done = 1'b0; e_cyc = 2; e_pc = pc1;
      end

      n = 0; got = 0;
      while (!got && n < 12) begin
        @(posedge clk);
        @(negedge clk);
        base_we = 1'b0;
        n++;
        if (done || illegal) got = 1;
      end
      check(VEC[i].req, "cycles to pulse", n, e_cyc);
      check(VEC[i].req, "done", done, e_done);
      check(VEC[i].req, "illegal", illegal, !e_done);
      check(VEC[i].req, "pc", pc, e_pc);
      check(VEC[i].req, "mode", mode, e_mode);
      check(2, "fetch_addr after op", fetch_addr, f_addr(e_pc, e_mode, m_base)); // R2
      check(11, "pulse exclusive", done && illegal, 0); // R11
      m_pc = e_pc;
      m_mode = e_mode;
    end

    // R11: pulse lasts one cycle, next fetch already under way (legal prefix in mode 0)
    a0 = f_addr(m_pc, m_mode, m_base);
    b0 = 8'h49; b1 = 8'hE9;
    @(posedge clk); @(negedge clk);
    check(11, "done clears", done, 0);
    check(11, "illegal clears", illegal, 0);
    check(3, "pc after one fetch", pc, f_inc(m_pc, m_mode)); // R3
    @(posedge clk); @(negedge clk);
    // R1: reset in the middle of a prefixed jump
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check(1, "mid reset pc", pc, 0);
    check(1, "mid reset mode", mode, 0);
    check(1, "mid reset fetch_addr", fetch_addr, 0);
    check(1, "mid reset done", done, 0);
    check(1, "mid reset illegal", illegal, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule